// File: doc/BRIEF.md
# Frame-Gated Serial Transmit Lane

This block is one transmit lane of a synchronous serial port. Software places a parallel word in a holding register, and the lane moves that word into a shift register at a word start. It then sends the word most significant bit first, one bit for each bit-clock tick. Word starts are set by a one-tick frame sync pulse. The pulse marks bit 0 of slot 0, and a new slot then begins every `WORD_LEN` ticks until the next pulse.

The lane enable works only at word boundaries. Setting the enable starts the lane at the next frame sync. Clearing it lets the current word finish before the output goes to high impedance. While the lane is idle, a flag pin can act as a software-driven general-purpose output for each frame in which the enable was clear at the frame start. The lane also reports when the holding register is empty, and it reports an underrun when it had to send a stale word.

Top module: `ser_tx_lane`

## Requirements
- R1: On each bit tick the lane advances one bit. Words are sent MSB first. A word starts on a tick with `fsync`=1, and after that on every `WORD_LEN`-th tick.
- R2: Setting the enable makes the lane active at the next word start that coincides with `fsync`, and at no earlier word start. While the lane is inactive, `sdo_oe`=0 and `sdo`=0.
- R3: Clearing the enable in the middle of a word lets that word finish. `sdo_oe` drops at the following word start.
- R4: If the enable is cleared and then set again within the same word, the lane keeps transmitting at the next word start with no gap.
- R5: If the enable is set again in a later slot, the output stays off until the next `fsync` word start.
- R6: While the lane is inactive, no word moves from the holding register to the shift register. Software writes are still accepted, and `tx_empty` stays 0 after such a write.
- R7: A transfer to the shift register sets `tx_empty`=1. A write to the holding register clears it.
- R8: If the lane is active and `tx_empty`=1 at a word start, the lane sends the last holding-register contents again and sets `tx_underrun`=1. A write clears `tx_underrun`.
- R9: With `sync_mode`=0 the enable is ignored and the lane stays inactive.
- R10: With `port_en`=0 the enable is treated as clear.
- R11: At every `fsync` tick, `flag_gpio` is set to 1 if the effective enable is clear and to 0 otherwise. `flag_out` equals `gp_flag` while `flag_gpio`=1, and is 0 otherwise.
- R12: After reset: `sdo_oe`=0, `sdo`=0, `tx_empty`=1, `tx_underrun`=0, `flag_gpio`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| fsync | input | 1 | Frame sync, valid with bit_tick, marks bit 0 of slot 0 |
| sync_mode | input | 1 | 1 = shared clock/sync mode; lane honoured only here |
| port_en | input | 1 | Global port enable |
| tx_en | input | 1 | Lane transmit enable |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | WORD_LEN | Holding-register write data |
| gp_flag | input | 1 | Software flag value for the flag pin |
| sdo | output | 1 | Serial data (0 when not driven) |
| sdo_oe | output | 1 | Serial data output enable |
| tx_empty | output | 1 | Holding register empty |
| tx_underrun | output | 1 | Stale word was sent |
| flag_gpio | output | 1 | Flag pin in general-purpose mode for this frame |
| flag_out | output | 1 | Flag pin value |

## Verification
The bench targets the three enable timings. A design that drops the output as soon as the enable clears would cut a word short. One that starts at any slot boundary would drive the line in the middle of a frame. One that restarts only at a frame sync would leave a gap after a quick off-and-on. The bench also checks that a write made while the lane is idle stays pending, and that an underrun sends the previous word again instead of zeros. Finally, it checks that asynchronous mode and a cleared port enable both keep the line in high impedance, and that the flag pin switches at frame starts only.

// File: rtl/ser_tx_pkg.sv
// Shared definitions for the serial transmit lane.
// Assumes word lengths are restricted to 8, 16 or 24 bits.
package ser_tx_pkg;
    // Returns 1 when the requested word length is supported.
    function automatic bit len_ok(input int len);
        return (len == 8) || (len == 16) || (len == 24);
    endfunction
endpackage

// File: rtl/ser_tx_timer.sv
// Bit position tracker. It counts bit ticks inside a word and flags word
// starts: a tick carrying fsync, or the tick after the last bit of a slot
// once a first fsync has been seen.
module ser_tx_timer #(
    parameter int WORD_LEN = 16,
    localparam int CNT_W = $clog2(WORD_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic fsync,
    output logic word_start
);
    logic [CNT_W-1:0] bit_idx;
    logic             framed;

    assign word_start = bit_tick &&
        (fsync || (framed && (bit_idx == CNT_W'(WORD_LEN - 1))));

    // Track the bit index and whether framing has been acquired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
            framed  <= 1'b0;
        end else if (bit_tick) begin
            if (fsync) framed <= 1'b1;
            bit_idx <= word_start ? '0 : bit_idx + 1'b1;
        end
    end

    p_slot_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !fsync && framed && bit_idx != CNT_W'(WORD_LEN - 1)) |-> !word_start);
endmodule

// File: rtl/ser_tx_hold.sv
// Holding register with empty and underrun status. Software writes win
// over a same-cycle transfer; a transfer of an empty register marks underrun
// and the stale contents are reused.
module ser_tx_hold #(
    parameter int WORD_LEN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_LEN-1:0] wr_data,
    input  logic                xfer,
    output logic [WORD_LEN-1:0] hold_q,
    output logic                empty,
    output logic                underrun
);
    // Capture software data and maintain status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            empty    <= 1'b1;
            underrun <= 1'b0;
        end else if (wr_en) begin
            hold_q   <= wr_data;
            empty    <= 1'b0;
            underrun <= 1'b0;
        end else if (xfer) begin
            empty <= 1'b1;
            if (empty) underrun <= 1'b1;
        end
    end

    p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!empty && !underrun));
    p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!underrun && !(xfer && empty)) |=> !underrun);
    p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !wr_en) |=> ($stable(empty) && $stable(hold_q)));
endmodule

// File: rtl/ser_tx_shift.sv
// Lane state and shift register. The active state may change only at a
// word start: it starts on an fsync word start when enabled, continues at
// slot starts while enabled, and otherwise stops once the word has finished.
module ser_tx_shift #(
    parameter int WORD_LEN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                fsync,
    input  logic                word_start,
    input  logic                lane_en,
    input  logic [WORD_LEN-1:0] load_data,
    output logic                xfer,
    output logic                active,
    output logic                ser_bit
);
    logic [WORD_LEN-1:0] shreg;

    assign xfer    = word_start && lane_en && (fsync || active);
    assign ser_bit = active && shreg[WORD_LEN-1];

    // Load at word start, shift on other ticks, update the active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            active <= 1'b0;
        end else if (word_start) begin
            active <= xfer;
            if (xfer) shreg <= load_data;
        end else if (bit_tick) begin
            shreg <= {shreg[WORD_LEN-2:0], 1'b0};
        end
    end

    p_start_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(bit_tick && fsync)) |=> !active);
    p_hold_midword_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_start |=> $stable(active));
    p_no_load_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !fsync) |-> !xfer);
endmodule

// File: rtl/ser_tx_flag.sv
// Flag pin mode select. At each frame start the pin becomes a software
// output for the frame if the lane enable is clear; the choice holds until
// the next frame start and never touches frame sync generation.
module ser_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic fsync,
    input  logic lane_en,
    input  logic gp_flag,
    output logic flag_gpio,
    output logic flag_out
);
    assign flag_out = flag_gpio && gp_flag;

    // Latch the flag pin mode at every frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_gpio <= 1'b0;
        else if (bit_tick && fsync) flag_gpio <= !lane_en;
    end

    p_mode_frame_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && fsync) |=> $stable(flag_gpio));
endmodule

// File: rtl/ser_tx_lane.sv
// Frame-gated serial transmit lane. It combines the bit timer, holding
// register, shifter and flag select. It assumes bit_tick is a one-cycle
// strobe and that fsync is only meaningful while bit_tick is high.
module ser_tx_lane #(
    parameter int WORD_LEN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                fsync,
    input  logic                sync_mode,
    input  logic                port_en,
    input  logic                tx_en,
    input  logic                wr_en,
    input  logic [WORD_LEN-1:0] wr_data,
    input  logic                gp_flag,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                tx_empty,
    output logic                tx_underrun,
    output logic                flag_gpio,
    output logic                flag_out
);
    import ser_tx_pkg::*;

    logic                lane_en;
    logic                word_start;
    logic                xfer;
    logic [WORD_LEN-1:0] hold_q;

    // Effective enable: honoured only in synchronous mode with the port on.
    assign lane_en = tx_en && port_en && sync_mode;

    generate
        if (!len_ok(WORD_LEN)) begin : g_bad_len
            initial assert (0) else $error("WORD_LEN must be 8, 16 or 24");
        end
    endgenerate

    ser_tx_timer #(.WORD_LEN(WORD_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
        .word_start(word_start)
    );

    ser_tx_hold #(.WORD_LEN(WORD_LEN)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .xfer(xfer), .hold_q(hold_q), .empty(tx_empty), .underrun(tx_underrun)
    );

    ser_tx_shift #(.WORD_LEN(WORD_LEN)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
        .word_start(word_start), .lane_en(lane_en), .load_data(hold_q),
        .xfer(xfer), .active(sdo_oe), .ser_bit(sdo)
    );

    ser_tx_flag u_flag (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
        .lane_en(lane_en), .gp_flag(gp_flag),
        .flag_gpio(flag_gpio), .flag_out(flag_out)
    );

    p_hiz_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);
    p_async_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !sdo_oe) |=> !sdo_oe);
    p_port_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !sdo_oe) |=> !sdo_oe);
endmodule

// File: tb/test_ser_tx_lane.sv
module test_ser_tx_lane;
    localparam int W = 8;
    localparam int NV = 5;
    localparam logic [W-1:0] VEC [NV] = '{8'hA5, 8'h3C, 8'hFF, 8'h01, 8'h80};

    logic clk = 1'b0;
    logic rst_n, bit_tick, fsync, sync_mode, port_en, tx_en, wr_en, gp_flag;
    logic [W-1:0] wr_data;
    logic sdo, sdo_oe, tx_empty, tx_underrun, flag_gpio, flag_out;
    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] got;
    logic oe_all, oe_any;

    always #2 clk = ~clk;

    ser_tx_lane #(.WORD_LEN(W)) i_ser_tx_lane (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
        .sync_mode(sync_mode), .port_en(port_en), .tx_en(tx_en),
        .wr_en(wr_en), .wr_data(wr_data), .gp_flag(gp_flag),
        .sdo(sdo), .sdo_oe(sdo_oe), .tx_empty(tx_empty),
        .tx_underrun(tx_underrun), .flag_gpio(flag_gpio), .flag_out(flag_out)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic cpu_write(input logic [W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One word of bit ticks; enable cleared before tick off_at, set before on_at.
    task automatic run_word(input logic fs, input int off_at, input int on_at);
        got = '0; oe_all = 1'b1; oe_any = 1'b0;
        for (int b = 0; b < W; b++) begin
            if (b == off_at) tx_en = 1'b0;
            if (b == on_at)  tx_en = 1'b1;
            bit_tick = 1'b1; fsync = fs && (b == 0);
            @(negedge clk);
            bit_tick = 1'b0; fsync = 1'b0;
            got = {got[W-2:0], sdo};
            oe_all &= sdo_oe; oe_any |= sdo_oe;
            if (!sdo_oe) chk(sdo == 1'b0, "R2 hi-z sdo", sdo, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0; bit_tick = 0; fsync = 0; sync_mode = 1; port_en = 1;
        tx_en = 0; wr_en = 0; wr_data = '0; gp_flag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sdo_oe && !sdo, "R12 oe/sdo", sdo_oe, 0);
        chk(tx_empty, "R12 empty", tx_empty, 1);
        chk(!tx_underrun, "R12 underrun", tx_underrun, 0);
        chk(!flag_gpio, "R12 flag_gpio", flag_gpio, 0);

        // Table walk: main shift function, R1 and R7.
        tx_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            cpu_write(VEC[v]);
            chk(!tx_empty, "R7 write clears empty", tx_empty, 0);
            run_word(1'b1, -1, -1);
            chk(got == VEC[v], "R1 word MSB first", got, VEC[v]);
            chk(oe_all, "R2 active from fsync", oe_all, 1);
            chk(tx_empty, "R7 transfer sets empty", tx_empty, 1);
        end

        // R8: empty at word start resends previous word.
        run_word(1'b1, -1, -1);
        chk(got == 8'h80, "R8 resend", got, 8'h80);
        chk(tx_underrun, "R8 underrun set", tx_underrun, 1);
        cpu_write(8'h5A);
        chk(!tx_underrun, "R8 write clears underrun", tx_underrun, 0);

        // R3: disable mid-word, word completes, then line released.
        run_word(1'b1, 3, -1);
        chk(got == 8'h5A && oe_all, "R3 word finishes", got, 8'h5A);
        run_word(1'b0, -1, -1);
        chk(!oe_any, "R3 off at next word", oe_any, 0);

        // R6: write while off stays pending.
        cpu_write(8'h77);
        run_word(1'b0, -1, -1);
        chk(!tx_empty, "R6 no transfer while off", tx_empty, 0);

        // R5: re-enable in a later slot waits for fsync.
        run_word(1'b0, -1, 2);
        chk(!oe_any, "R5 off in enabling slot", oe_any, 0);
        run_word(1'b0, -1, -1);
        chk(!oe_any, "R5 off at slot start w/o fsync", oe_any, 0);
        chk(!tx_empty, "R6 still pending", tx_empty, 0);
        run_word(1'b1, -1, -1);
        chk(oe_all && got == 8'h77, "R2 start at fsync", got, 8'h77);

        // R4: clear then set within the same word continues with no gap.
        cpu_write(8'h11);
        run_word(1'b1, 2, 5);
        chk(got == 8'h11, "R4 word sent", got, 8'h11);
        cpu_write(8'h22);
        run_word(1'b0, -1, -1);
        chk(oe_all && got == 8'h22, "R4 continued", got, 8'h22);

        // R9: asynchronous mode ignores enable.
        sync_mode = 1'b0;
        run_word(1'b1, -1, -1);
        run_word(1'b1, -1, -1);
        chk(!oe_any, "R9 async off", oe_any, 0);
        chk(flag_gpio, "R9 flag gpio in async", flag_gpio, 1);
        sync_mode = 1'b1;

        // R10: port disable forces enable clear.
        port_en = 1'b0;
        run_word(1'b1, -1, -1);
        chk(!oe_any, "R10 port off", oe_any, 0);
        port_en = 1'b1;

        // R11: flag pin mode latched at frame start.
        tx_en = 1'b0; gp_flag = 1'b1;
        run_word(1'b1, -1, -1);
        chk(flag_gpio && flag_out, "R11 gpio drives 1", flag_out, 1);
        gp_flag = 1'b0;
        @(negedge clk);
        chk(!flag_out, "R11 gpio drives 0", flag_out, 0);
        tx_en = 1'b1; gp_flag = 1'b1;
        run_word(1'b0, -1, -1);
        chk(flag_gpio, "R11 held until frame start", flag_gpio, 1);
        run_word(1'b1, -1, -1);
        chk(!flag_gpio && !flag_out, "R11 released when enabled", flag_gpio, 0);

        summary();
    end
endmodule